// File: doc/BRIEF.md
# Multi-Mode General-Purpose Pin Controller

This block sets up eight general-purpose pins from a packed set of per-pin 3-bit mode codes. For each pin it produces pad controls: output enable, output value, weak pull-up, weak pull-down, analog-measure select and temperature-protector select. It also reports one status bit per pin. Digital pin levels pass through a synchronizer before they reach status or any internal logic.

On fixed pins, special takeover functions replace the per-pin mode:
- a conversion-ready indicator on pin 1;
- a balancing-active output on pin 3;
- the SPI master lines on pins 4 to 7;
- an active-low fault input on pin 8.

The fault input feeds a sticky fault bit, which is cleared by a write-one-to-clear strobe. It also drives a shared active-low fault output. A shutdown input overrides everything and applies a weak pull-down on every pin.

All ports are plain control and status signals. There is no stream interface, so the block has no valid/ready handshake and no back-pressure.

Top module: `pin_mux_ctrl`

## Requirements
- R1: With mode code 0 (disabled) on a pin, that pin has output enable, pull-up, pull-down, analog select, temperature select and status all 0. After reset, `fault_gpio` is 0 and `nfault` is 1.
- R2: Mode code 1 sets both analog select and temperature select on the pin. Mode code 2 sets only analog select. In both modes the output enable is 0.
- R3: Mode code 3 (digital input) keeps output enable at 0. The pin's status bit follows `pad_in` through a two-flop synchronizer, so a new level first appears in status after the second rising edge that follows the change.
- R4: Mode code 4 drives the pin high and mode code 5 drives it low (output enable 1). In both modes the status bit equals the driven value.
- R5: Mode code 6 sets pull-up and analog select. Mode code 7 sets pull-down and analog select. Pull-up and pull-down are never both set on one pin.
- R6: While `shutdown` is 1, every pin has pull-down 1, and output enable, pull-up, analog select, temperature select and status all 0. This holds whatever the mode codes and special enables are.
- R7: While `spi_en` is 1, the SPI master takes over four pins, overriding their mode codes:
  - bit 3 drives `spi_ss`;
  - bit 5 drives `spi_mosi`;
  - bit 6 drives `spi_sclk`;
  - bit 4 is an input (output enable 0), and `spi_miso` equals `pad_in[4]` combinationally.
- R8: While `fault_in_en` is 1, pin bit 7 is an input (output enable 0). When its synchronized level is low, `fault_gpio` is set, and it stays set until `fault_clr` is pulsed while the pin is high.
- R9: `nfault` is 0 exactly when `fault_gpio` and `fault_out_en` are both 1.
- R10: While `rdy_out_en` is 1, pin bit 0 is driven:
  - low from the edge after a `cs_conv_done` pulse;
  - high again from the edge after a `rd_cur_hi` pulse;
  - low if both pulses arrive in the same cycle, because a new result takes priority.
  Clearing `rdy_out_en` resets the flag.
- R11: While `bal_timer` is nonzero, pin bit 2 drives high with status 1.
- R12: A special pin whose takeover is not enabled follows its own mode code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | NPINS*3 | Per-pin mode codes, pin i at bits [3i+2:3i] |
| shutdown | input | 1 | Forces weak pull-down on all pins |
| spi_en | input | 1 | SPI master pin takeover |
| fault_in_en | input | 1 | Fault-input takeover of pin bit 7 |
| fault_out_en | input | 1 | Enables the shared fault output |
| fault_clr | input | 1 | Write-one-to-clear strobe for the fault bit |
| rdy_out_en | input | 1 | Conversion-ready takeover of pin bit 0 |
| cs_conv_done | input | 1 | Current-sense conversion complete pulse |
| rd_cur_hi | input | 1 | Host read of current result high byte |
| bal_timer | input | BAL_W | Balancing timer control, nonzero means active |
| spi_ss | input | 1 | Select line from SPI master |
| spi_mosi | input | 1 | Data out from SPI master |
| spi_sclk | input | 1 | Clock from SPI master |
| spi_miso | output | 1 | Data in to SPI master |
| pad_in | input | NPINS | Pad input levels |
| pad_oe | output | NPINS | Output enable per pin |
| pad_out | output | NPINS | Output value per pin |
| pad_pu | output | NPINS | Weak pull-up per pin |
| pad_pd | output | NPINS | Weak pull-down per pin |
| pad_ana | output | NPINS | Analog measure select per pin |
| pad_temp | output | NPINS | Temperature protector input select per pin |
| pin_stat | output | NPINS | Pin level status |
| fault_gpio | output | 1 | Sticky pin fault bit |
| nfault | output | 1 | Shared active-low fault output |

## Verification
The bench builds the block with its defaults: eight pins, a two-stage synchronizer and an 8-bit balancing timer. All four special pin positions are therefore present, and the two-edge input latency can be checked exactly. One directed scenario covers each mode pair and each takeover. It probes the fault latch on the cycles around its set edge, a clear attempted while the pin is still low, and ready-flag set and release pulses that arrive together.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

  typedef enum logic [2:0] {
    PM_OFF      = 3'd0,
    PM_ANA_TEMP = 3'd1,
    PM_ANA      = 3'd2,
    PM_DIN      = 3'd3,
    PM_DRV_HI   = 3'd4,
    PM_DRV_LO   = 3'd5,
    PM_ANA_PU   = 3'd6,
    PM_ANA_PD   = 3'd7
  } pin_mode_e;

  typedef struct packed {
    logic oe;
    logic out;
    logic pu;
    logic pd;
    logic ana;
    logic temp;
    logic stat;
  } pad_ctl_t;

  // Fixed positions of the takeover functions (0-based pin index)
  localparam int PIN_RDY  = 0;
  localparam int PIN_BAL  = 2;
  localparam int PIN_SS   = 3;
  localparam int PIN_MISO = 4;
  localparam int PIN_MOSI = 5;
  localparam int PIN_SCLK = 6;
  localparam int PIN_FLT  = 7;

  function automatic pad_ctl_t ctl_drive(logic v);
    pad_ctl_t c;
    c      = '0;
    c.oe   = 1'b1;
    c.out  = v;
    c.stat = v;
    return c;
  endfunction

  function automatic pad_ctl_t ctl_input(logic lvl);
    pad_ctl_t c;
    c      = '0;
    c.stat = lvl;
    return c;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int NPINS  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] d,
  output logic [NPINS-1:0] q
);
  logic [NPINS-1:0] stg [STAGES];

  // Reset to idle-high so an active-low input cannot fire out of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '1;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_mode_dec.sv
module gpio_mode_dec
  import pinmux_pkg::*;
(
  input  pin_mode_e mode,
  input  logic      din,
  output pad_ctl_t  ctl
);
  always_comb begin
    ctl = '0;
    unique case (mode)
      PM_OFF:      ctl = '0;
      PM_ANA_TEMP: begin ctl.ana = 1'b1; ctl.temp = 1'b1; end
      PM_ANA:      ctl.ana = 1'b1;
      PM_DIN:      ctl = ctl_input(din);
      PM_DRV_HI:   ctl = ctl_drive(1'b1);
      PM_DRV_LO:   ctl = ctl_drive(1'b0);
      PM_ANA_PU:   begin ctl.pu = 1'b1; ctl.ana = 1'b1; end
      PM_ANA_PD:   begin ctl.pd = 1'b1; ctl.ana = 1'b1; end
      default:     ctl = '0;
    endcase
  end
endmodule

// File: rtl/gpio_special.sv
module gpio_special (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_en,
  input  logic flt_lvl,
  input  logic fault_clr,
  input  logic rdy_en,
  input  logic conv_done,
  input  logic rd_hi,
  output logic fault_q,
  output logic rdy_low_q
);
  // Sticky fault: a live low level wins over a clear request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     fault_q <= 1'b0;
    else if (fault_en && !flt_lvl)  fault_q <= 1'b1;
    else if (fault_clr)             fault_q <= 1'b0;
  end

  // Ready flag: a fresh result wins over a simultaneous read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdy_low_q <= 1'b0;
    else if (!rdy_en)   rdy_low_q <= 1'b0;
    else if (conv_done) rdy_low_q <= 1'b1;
    else if (rd_hi)     rdy_low_q <= 1'b0;
  end
endmodule

// File: rtl/pin_mux_ctrl.sv
module pin_mux_ctrl
  import pinmux_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int BAL_W       = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPINS*3-1:0]     cfg_mode,
  input  logic                   shutdown,
  input  logic                   spi_en,
  input  logic                   fault_in_en,
  input  logic                   fault_out_en,
  input  logic                   fault_clr,
  input  logic                   rdy_out_en,
  input  logic                   cs_conv_done,
  input  logic                   rd_cur_hi,
  input  logic [BAL_W-1:0]       bal_timer,
  input  logic                   spi_ss,
  input  logic                   spi_mosi,
  input  logic                   spi_sclk,
  output logic                   spi_miso,
  input  logic [NPINS-1:0]       pad_in,
  output logic [NPINS-1:0]       pad_oe,
  output logic [NPINS-1:0]       pad_out,
  output logic [NPINS-1:0]       pad_pu,
  output logic [NPINS-1:0]       pad_pd,
  output logic [NPINS-1:0]       pad_ana,
  output logic [NPINS-1:0]       pad_temp,
  output logic [NPINS-1:0]       pin_stat,
  output logic                   fault_gpio,
  output logic                   nfault
);
  localparam int MODE_W = $bits(pin_mode_e);

  logic [NPINS-1:0] din_s;
  pad_ctl_t         base [NPINS];
  pad_ctl_t         fin  [NPINS];
  logic             rdy_low;

  gpio_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(din_s)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_mode_dec u_dec (
      .mode(pin_mode_e'(cfg_mode[i*MODE_W +: MODE_W])),
      .din (din_s[i]),
      .ctl (base[i])
    );
  end

  gpio_special u_spec (
    .clk(clk), .rst_n(rst_n),
    .fault_en(fault_in_en), .flt_lvl(din_s[PIN_FLT]), .fault_clr(fault_clr),
    .rdy_en(rdy_out_en), .conv_done(cs_conv_done), .rd_hi(rd_cur_hi),
    .fault_q(fault_gpio), .rdy_low_q(rdy_low)
  );

  // Priority: shutdown > takeover functions > per-pin mode
  always_comb begin
    for (int i = 0; i < NPINS; i++) fin[i] = base[i];
    if (rdy_out_en)        fin[PIN_RDY] = ctl_drive(~rdy_low);
    if (|bal_timer)        fin[PIN_BAL] = ctl_drive(1'b1);
    if (spi_en) begin
      fin[PIN_SS]   = ctl_drive(spi_ss);
      fin[PIN_MISO] = ctl_input(din_s[PIN_MISO]);
      fin[PIN_MOSI] = ctl_drive(spi_mosi);
      fin[PIN_SCLK] = ctl_drive(spi_sclk);
    end
    if (fault_in_en)       fin[PIN_FLT] = ctl_input(din_s[PIN_FLT]);
    if (shutdown) begin
      for (int i = 0; i < NPINS; i++) begin
        fin[i]    = '0;
        fin[i].pd = 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      pad_oe[i]   = fin[i].oe;
      pad_out[i]  = fin[i].out;
      pad_pu[i]   = fin[i].pu;
      pad_pd[i]   = fin[i].pd;
      pad_ana[i]  = fin[i].ana;
      pad_temp[i] = fin[i].temp;
      pin_stat[i] = fin[i].stat;
    end
  end

  // MISO is passed unsynchronized: the SPI master samples it on its own clock
  assign spi_miso = pad_in[PIN_MISO];
  assign nfault   = ~(fault_gpio & fault_out_en);

endmodule

// File: rtl/pin_mux_ctrl_chk.sv
module pin_mux_ctrl_chk
  import pinmux_pkg::*;
#(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shutdown,
  input logic             spi_en,
  input logic             fault_out_en,
  input logic             fault_clr,
  input logic             fault_gpio,
  input logic             nfault,
  input logic             rdy_out_en,
  input logic             rd_cur_hi,
  input logic             cs_conv_done,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_pu,
  input logic [NPINS-1:0] pad_pd
);
  assert_shutdown_pulldown_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (&pad_pd && pad_oe == '0 && pad_pu == '0));

  assert_pull_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_pd) == '0);

  assert_miso_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && !shutdown) |-> !pad_oe[PIN_MISO]);

  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_gpio && !fault_clr) |=> fault_gpio);

  assert_nfault_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_out_en |-> nfault);

  assert_nfault_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_gpio && fault_out_en) |-> !nfault);

  assert_ready_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_out_en && rd_cur_hi && !cs_conv_done) |=>
      (shutdown || !rdy_out_en || pad_out[PIN_RDY]));

  assert_ready_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_out_en && cs_conv_done) |=>
      (shutdown || !rdy_out_en || (pad_oe[PIN_RDY] && !pad_out[PIN_RDY])));
endmodule

bind pin_mux_ctrl pin_mux_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .shutdown(shutdown), .spi_en(spi_en),
  .fault_out_en(fault_out_en), .fault_clr(fault_clr), .fault_gpio(fault_gpio),
  .nfault(nfault), .rdy_out_en(rdy_out_en), .rd_cur_hi(rd_cur_hi),
  .cs_conv_done(cs_conv_done), .pad_oe(pad_oe), .pad_out(pad_out),
  .pad_pu(pad_pu), .pad_pd(pad_pd)
);

// File: tb/tb_pin_mux_ctrl.sv
module tb_pin_mux_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NPINS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NPINS*3-1:0] cfg_mode = '0;
  logic shutdown = 0, spi_en = 0, fault_in_en = 0, fault_out_en = 0, fault_clr = 0;
  logic rdy_out_en = 0, cs_conv_done = 0, rd_cur_hi = 0;
  logic [7:0] bal_timer = '0;
  logic spi_ss = 1, spi_mosi = 0, spi_sclk = 0, spi_miso;
  logic [NPINS-1:0] pad_in = '1;
  logic [NPINS-1:0] pad_oe, pad_out, pad_pu, pad_pd, pad_ana, pad_temp, pin_stat;
  logic fault_gpio, nfault;

  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_mux_ctrl dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_mode(int pin, logic [2:0] m);
    cfg_mode[pin*3 +: 3] = m;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 oe", 32'(pad_oe), 0);
    chk("R1 pu|pd|ana|temp", 32'(pad_pu | pad_pd | pad_ana | pad_temp), 0);
    chk("R1 stat", 32'(pin_stat), 0);
    chk("R1 fault", 32'(fault_gpio), 0);
    chk("R1 nfault", 32'(nfault), 1);
  endtask

  task automatic t_analog;
    set_mode(0, 3'd1); set_mode(1, 3'd2); tick(1);
    chk("R2 ana", 32'(pad_ana), 32'h03);
    chk("R2 temp", 32'(pad_temp), 32'h01);
    chk("R2 oe", 32'(pad_oe), 0);
    cfg_mode = '0;
  endtask

  task automatic t_din;
    set_mode(2, 3'd3); tick(3);
    chk("R3 stat high", 32'(pin_stat), 32'h04);
    pad_in[2] = 1'b0;
    tick(1);
    chk("R3 still old after one edge", 32'(pin_stat[2]), 1);
    tick(1);
    chk("R3 new after two edges", 32'(pin_stat[2]), 0);
    chk("R3 oe", 32'(pad_oe[2]), 0);
    pad_in[2] = 1'b1; cfg_mode = '0; tick(3);
  endtask

  task automatic t_drive;
    set_mode(0, 3'd4); set_mode(1, 3'd5); tick(1);
    chk("R4 oe", 32'(pad_oe), 32'h03);
    chk("R4 out", 32'(pad_out[1:0]), 32'h1);
    chk("R4 stat", 32'(pin_stat), 32'h01);
    cfg_mode = '0;
  endtask

  task automatic t_pull;
    set_mode(4, 3'd6); set_mode(5, 3'd7); tick(1);
    chk("R5 pu", 32'(pad_pu), 32'h10);
    chk("R5 pd", 32'(pad_pd), 32'h20);
    chk("R5 ana", 32'(pad_ana), 32'h30);
    cfg_mode = '0;
  endtask

  task automatic t_spi;
    for (int p = 3; p <= 6; p++) set_mode(p, 3'd4);
    spi_en = 1; spi_ss = 0; spi_mosi = 1; spi_sclk = 0; pad_in[4] = 0;
    #1;
    chk("R7 oe", 32'(pad_oe[6:3]), 32'b1101);
    chk("R7 out", 32'({pad_out[6], pad_out[5], pad_out[3]}), 32'b010);
    chk("R7 miso low", 32'(spi_miso), 0);
    pad_in[4] = 1; #1;
    chk("R7 miso high", 32'(spi_miso), 1);
    spi_ss = 1; spi_sclk = 1; #1;
    chk("R7 ss/sclk follow", 32'({pad_out[6], pad_out[3]}), 32'b11);
    spi_en = 0; #1;
    chk("R12 spi off follows mode", 32'(pad_oe[6:3] & pad_out[6:3]), 32'hF);
    cfg_mode = '0; tick(1);
  endtask

  task automatic t_fault;
    set_mode(7, 3'd4); fault_in_en = 1; #1;
    chk("R8 takeover input", 32'(pad_oe[7]), 0);
    pad_in[7] = 0;
    tick(2);
    chk("R8 not yet set", 32'(fault_gpio), 0);
    tick(1);
    chk("R8 set", 32'(fault_gpio), 1);
    chk("R9 nfault masked", 32'(nfault), 1);
    fault_out_en = 1; #1;
    chk("R9 nfault asserted", 32'(nfault), 0);
    fault_clr = 1; tick(1); fault_clr = 0;
    chk("R8 clear while low ignored", 32'(fault_gpio), 1);
    pad_in[7] = 1; tick(4);
    chk("R8 sticky", 32'(fault_gpio), 1);
    fault_clr = 1; tick(1); fault_clr = 0;
    chk("R8 cleared", 32'(fault_gpio), 0);
    chk("R9 nfault released", 32'(nfault), 1);
    fault_in_en = 0; fault_out_en = 0; #1;
    chk("R12 fault off follows mode", 32'(pad_oe[7] & pad_out[7]), 1);
    cfg_mode = '0;
  endtask

  task automatic t_ready;
    rdy_out_en = 1; #1;
    chk("R10 idle high", 32'({pad_oe[0], pad_out[0]}), 32'b11);
    cs_conv_done = 1; tick(1); cs_conv_done = 0;
    chk("R10 low on done", 32'(pad_out[0]), 0);
    tick(2);
    chk("R10 held low", 32'(pad_out[0]), 0);
    rd_cur_hi = 1; tick(1); rd_cur_hi = 0;
    chk("R10 high after read", 32'(pad_out[0]), 1);
    cs_conv_done = 1; rd_cur_hi = 1; tick(1); cs_conv_done = 0; rd_cur_hi = 0;
    chk("R10 done beats read", 32'(pad_out[0]), 0);
    rdy_out_en = 0; tick(1); rdy_out_en = 1; #1;
    chk("R10 disable resets flag", 32'(pad_out[0]), 1);
    rdy_out_en = 0; tick(1);
  endtask

  task automatic t_bal;
    set_mode(2, 3'd5); bal_timer = 8'h05; #1;
    chk("R11 bal drive", 32'({pad_oe[2], pad_out[2], pin_stat[2]}), 32'b111);
    bal_timer = 0; #1;
    chk("R12 bal off follows mode", 32'({pad_oe[2], pad_out[2]}), 32'b10);
    cfg_mode = '0;
  endtask

  task automatic t_shutdown;
    set_mode(0, 3'd4); set_mode(1, 3'd6); set_mode(2, 3'd1); set_mode(3, 3'd3);
    spi_en = 1; bal_timer = 8'h01; shutdown = 1; #1;
    chk("R6 pd", 32'(pad_pd), 32'hFF);
    chk("R6 oe|pu|ana|temp", 32'(pad_oe | pad_pu | pad_ana | pad_temp), 0);
    chk("R6 stat", 32'(pin_stat), 0);
    shutdown = 0; spi_en = 0; bal_timer = 0; cfg_mode = '0; tick(1);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(2);
    t_reset();
    t_analog();
    t_din();
    t_drive();
    t_pull();
    t_spi();
    t_fault();
    t_ready();
    t_bal();
    t_shutdown();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule